// File: doc/BRIEF.md
# Lane Character Error Counter

This block keeps a running tally of character-level receive faults on a single lane of an 8b/10b link. Every clock it looks at one beat of decoder output, several octets wide. For each octet the decoder reports a running-disparity fault, a code-group-not-found fault, and whether the octet is a control character, together with its decoded value. Each fault class that is not masked adds one to the tally for each octet where it is present. All octets of a beat are added together in the same cycle.

A control character counts as unexpected when the low five bits of its decoded value are not the K28 pattern. While the lane is still in code group synchronisation, nothing is added. A control word sets the behaviour. One bit of it zeroes the tally, and three bits mask the three fault classes one by one. The tally is 32 bits wide and software reads it. It saturates instead of wrapping.

The input beat uses the valid half of a valid/ready stream. The block can take a beat every cycle, so it never applies back-pressure and has no ready output. A cycle with `beat_valid` low carries no beat and changes nothing. The control pins and the count output are plain level signals.

Top module: `rx_lane_err_counter`

## Requirements
- R1: After reset `err_count` is 0.
- R2: On a cycle where a beat is accepted, `err_count` grows by the total number of unmasked fault flags across all OCTETS octets and all three classes. The new value shows one clock after the beat is sampled. With default parameters the count is 32 bits wide.
- R3: Each octet with `disp_err` set adds one. Bit 8 of `ctrl_word` at 1 stops these from being counted.
- R4: Each octet with `nit_err` set adds one. Bit 9 of `ctrl_word` at 1 stops these from being counted.
- R5: An octet with `is_ctrl` set adds one when bits [4:0] of its decoded value (octet i is `octet_data[8*i+7:8*i]`) are not 5'b11100. K28.x characters add nothing, and an octet with `is_ctrl` clear adds nothing for this class. Bit 10 of `ctrl_word` at 1 stops these from being counted.
- R6: While bit 0 of `ctrl_word` is 1, the count is 0 one clock later and stays 0, whatever faults arrive.
- R7: While `cgs_phase` is 1, no faults are added.
- R8: A cycle with `beat_valid` at 0 adds nothing.
- R9: The count saturates at its all-ones value and does not wrap.
- R10: `ctrl_word` bits other than 0, 8, 9 and 10 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid | input | 1 | Beat present this cycle |
| disp_err | input | OCTETS | Per-octet disparity fault |
| nit_err | input | OCTETS | Per-octet code-group-not-found fault |
| is_ctrl | input | OCTETS | Per-octet control character flag |
| octet_data | input | 8*OCTETS | Decoded octets, octet 0 in the low byte |
| cgs_phase | input | 1 | Lane is in code group synchronisation |
| ctrl_word | input | 32 | Bit 0 clear, bit 8/9/10 mask disparity/not-in-table/unexpected-K |
| err_count | output | CNT_W | Saturating fault tally |

## Verification
The count has a single register between the inputs and `err_count`, so every result is due one clock after the beat. This applies to a beat with faults, a masked beat, a clear request and a held-off beat alike. The bench drives inputs on the falling edge and compares `err_count` on the next falling edge, half a period after the rising edge that registers the result. To cover saturation in a short run, the bench also runs an 8-bit copy from the same stimulus and keeps a separate saturating model for it.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int unsigned CTRL_W        = 32;
  localparam int unsigned CLR_BIT       = 0;
  localparam int unsigned MASK_DISP_BIT = 8;
  localparam int unsigned MASK_NIT_BIT  = 9;
  localparam int unsigned MASK_UK_BIT   = 10;
  localparam logic [4:0]  K28_LOW5      = 5'b11100;
  localparam int unsigned NUM_CLASSES   = 3;

  typedef struct packed {
    logic uk;
    logic nit;
    logic disp;
  } err_mask_t;

  function automatic int unsigned inc_width(input int unsigned octets);
    return $clog2(NUM_CLASSES * octets + 1);
  endfunction
endpackage

// File: rtl/rx_err_classify.sv
module rx_err_classify
  import rx_err_pkg::*;
#(
  parameter int unsigned OCTETS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  count_en,
  input  err_mask_t             mask,
  input  logic [OCTETS-1:0]     disp_err,
  input  logic [OCTETS-1:0]     nit_err,
  input  logic [OCTETS-1:0]     is_ctrl,
  input  logic [8*OCTETS-1:0]   octet_data,
  output logic [3*OCTETS-1:0]   hits
);
  logic [OCTETS-1:0] disp_hit;
  logic [OCTETS-1:0] nit_hit;
  logic [OCTETS-1:0] uk_hit;

  for (genvar i = 0; i < OCTETS; i++) begin : g_oct
    logic [7:0] oct;
    logic       unexpected_k;
    assign oct          = octet_data[8*i +: 8];
    assign unexpected_k = is_ctrl[i] && (oct[4:0] != K28_LOW5);
    assign disp_hit[i]  = count_en && !mask.disp && disp_err[i];
    assign nit_hit[i]   = count_en && !mask.nit  && nit_err[i];
    assign uk_hit[i]    = count_en && !mask.uk   && unexpected_k;

    // R5
    k28_never_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ctrl[i] && (octet_data[8*i +: 5] == K28_LOW5)) |-> !hits[3*i+2]);
    // R5
    data_char_never_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_ctrl[i] |-> !hits[3*i+2]);
  end

  for (genvar i = 0; i < OCTETS; i++) begin : g_pack
    assign hits[3*i +: 3] = {uk_hit[i], nit_hit[i], disp_hit[i]};
  end

  // R3
  disp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask.disp |-> (disp_hit == '0));
  // R4
  nit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask.nit |-> (nit_hit == '0));
endmodule

// File: rtl/rx_err_popcount.sv
module rx_err_popcount
  import rx_err_pkg::*;
#(
  parameter int unsigned OCTETS = 4,
  localparam int unsigned N     = NUM_CLASSES * OCTETS,
  localparam int unsigned INC_W = inc_width(OCTETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     hits,
  output logic [INC_W-1:0] total
);
  always_comb begin
    total = '0;
    for (int j = 0; j < N; j++) begin
      total = total + INC_W'(hits[j]);
    end
  end

  // R2
  total_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total <= INC_W'(N));
  // R2
  zero_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hits == '0) |-> (total == '0));
endmodule

// File: rtl/rx_err_sat_counter.sv
module rx_err_sat_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAX_CNT = '1;

  logic [CNT_W:0]   sum_wide;
  logic [CNT_W-1:0] next_cnt;

  always_comb begin
    sum_wide = {1'b0, count} + (CNT_W+1)'(inc);
    next_cnt = sum_wide[CNT_W] ? MAX_CNT : sum_wide[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else               count <= next_cnt;
  end

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count == MAX_CNT) |=> (count == MAX_CNT));
  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count >= $past(count)));
  // R2
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((count - $past(count)) <= CNT_W'($past(inc))));
endmodule

// File: rtl/rx_lane_err_counter.sv
module rx_lane_err_counter
  import rx_err_pkg::*;
#(
  parameter int unsigned OCTETS = 4,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned INC_W = inc_width(OCTETS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  beat_valid,
  input  logic [OCTETS-1:0]     disp_err,
  input  logic [OCTETS-1:0]     nit_err,
  input  logic [OCTETS-1:0]     is_ctrl,
  input  logic [8*OCTETS-1:0]   octet_data,
  input  logic                  cgs_phase,
  input  logic [CTRL_W-1:0]     ctrl_word,
  output logic [CNT_W-1:0]      err_count
);
  logic                     count_en;
  err_mask_t                mask;
  logic [3*OCTETS-1:0]      hits;
  logic [INC_W-1:0]         inc;

  assign count_en = beat_valid && !cgs_phase;
  assign mask     = '{uk:   ctrl_word[MASK_UK_BIT],
                      nit:  ctrl_word[MASK_NIT_BIT],
                      disp: ctrl_word[MASK_DISP_BIT]};

  rx_err_classify #(.OCTETS(OCTETS)) u_classify (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_en   (count_en),
    .mask       (mask),
    .disp_err   (disp_err),
    .nit_err    (nit_err),
    .is_ctrl    (is_ctrl),
    .octet_data (octet_data),
    .hits       (hits)
  );

  rx_err_popcount #(.OCTETS(OCTETS)) u_popcount (
    .clk   (clk),
    .rst_n (rst_n),
    .hits  (hits),
    .total (inc)
  );

  rx_err_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctrl_word[CLR_BIT]),
    .inc   (inc),
    .count (err_count)
  );

  // R7
  cgs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cgs_phase && !ctrl_word[CLR_BIT]) |=> $stable(err_count));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_valid && !ctrl_word[CLR_BIT]) |=> $stable(err_count));
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (err_count == '0));
endmodule

// File: tb/rx_lane_err_counter_tb.sv
module rx_lane_err_counter_tb;
  localparam int OCT = 4;
  localparam int NV  = 17;
  // {valid, cgs, mask[k,nit,disp], disp, nit, isk, data, exp_inc}
  localparam logic [52:0] VEC [NV] = '{
    {1'b1,1'b0,3'b000,4'b0001,4'b0000,4'b0000,32'h0000_0000,4'd1},  // R3
    {1'b1,1'b0,3'b000,4'b1111,4'b0000,4'b0000,32'h0000_0000,4'd4},  // R3
    {1'b1,1'b0,3'b000,4'b0000,4'b0101,4'b0000,32'h0000_0000,4'd2},  // R4
    {1'b1,1'b0,3'b000,4'b0011,4'b0011,4'b0000,32'h0000_0000,4'd4},  // R2
    {1'b1,1'b0,3'b001,4'b1111,4'b0001,4'b0000,32'h0000_0000,4'd1},  // R3 masked
    {1'b1,1'b0,3'b010,4'b0010,4'b1111,4'b0000,32'h0000_0000,4'd1},  // R4 masked
    {1'b1,1'b0,3'b000,4'b0000,4'b0000,4'b0001,32'h0000_001C,4'd0},  // R5 K28.0
    {1'b1,1'b0,3'b000,4'b0000,4'b0000,4'b0001,32'h0000_00BC,4'd0},  // R5 K28.5
    {1'b1,1'b0,3'b000,4'b0000,4'b0000,4'b0010,32'h0000_3C00,4'd0},  // R5 K28.1
    {1'b1,1'b0,3'b000,4'b0000,4'b0000,4'b0001,32'h0000_00FB,4'd1},  // R5
    {1'b1,1'b0,3'b000,4'b0000,4'b0000,4'b1111,32'hFBF7_FEBC,4'd3},  // R5
    {1'b1,1'b0,3'b100,4'b0000,4'b0000,4'b1111,32'hFBF7_FEBC,4'd0},  // R5 masked
    {1'b1,1'b1,3'b000,4'b1111,4'b1111,4'b1111,32'hFBFB_FBFB,4'd0},  // R7
    {1'b0,1'b0,3'b000,4'b1111,4'b1111,4'b1111,32'hFBFB_FBFB,4'd0},  // R8
    {1'b1,1'b0,3'b000,4'b1111,4'b1111,4'b1111,32'hFBFB_FBFB,4'd12}, // R2
    {1'b1,1'b0,3'b111,4'b1111,4'b1111,4'b1111,32'hFBFB_FBFB,4'd0},  // R3 R4 R5
    {1'b1,1'b0,3'b000,4'b0000,4'b0000,4'b0000,32'hFBFB_FBFB,4'd0}   // R5 data
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            beat_valid;
  logic [OCT-1:0]  disp_err, nit_err, is_ctrl;
  logic [8*OCT-1:0] octet_data;
  logic            cgs_phase;
  logic [31:0]     ctrl_word;
  logic [31:0]     err_count;
  logic [7:0]      small_count;

  int applied = 0;
  int fails   = 0;
  logic [31:0] exp_big;
  logic [7:0]  exp_small;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  rx_lane_err_counter #(.OCTETS(OCT), .CNT_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .disp_err(disp_err),
    .nit_err(nit_err), .is_ctrl(is_ctrl), .octet_data(octet_data),
    .cgs_phase(cgs_phase), .ctrl_word(ctrl_word), .err_count(err_count));

  rx_lane_err_counter #(.OCTETS(OCT), .CNT_W(8)) u_dut_sat (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .disp_err(disp_err),
    .nit_err(nit_err), .is_ctrl(is_ctrl), .octet_data(octet_data),
    .cgs_phase(cgs_phase), .ctrl_word(ctrl_word), .err_count(small_count));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic add_exp(input int inc);
    exp_big = exp_big + 32'(inc);
    exp_small = (int'(exp_small) + inc > 255) ? 8'hFF : 8'(int'(exp_small) + inc);
  endtask

  task automatic drive(input logic v, input logic c, input logic [2:0] m,
                       input logic [3:0] d, input logic [3:0] n, input logic [3:0] k,
                       input logic [31:0] dat, input logic [31:0] extra);
    beat_valid = v; cgs_phase = c;
    disp_err = d; nit_err = n; is_ctrl = k; octet_data = dat;
    ctrl_word = {21'b0, m, 8'b0} | extra;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  endtask

  initial begin
    #400us;
    if (!done) begin
      fails++;
      applied++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 3'b000, 4'hF, 4'hF, 4'hF, 32'hFBFB_FBFB, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 3'b000, 4'h0, 4'h0, 4'h0, 32'h0, 32'h0);
    @(negedge clk);
    check("R1 reset big", err_count, 32'd0);
    check("R1 reset small", {24'b0, small_count}, 32'd0);
    exp_big = 0; exp_small = 0;

    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      v = VEC[i];
      drive(v[52], v[51], v[50:48], v[47:44], v[43:40], v[39:36], v[35:4], 32'h0);
      add_exp(int'(v[3:0]));
      @(negedge clk);
      check($sformatf("R2 vector %0d", i), err_count, exp_big);
    end

    // R10: unused control bits set, masks and clear off
    drive(1'b1, 1'b0, 3'b000, 4'hF, 4'hF, 4'hF, 32'hFBFB_FBFB, 32'hFFFF_F8FE);
    add_exp(12);
    @(negedge clk);
    check("R10 unused ctrl bits", err_count, exp_big);

    // R6: clear overrides faults and holds
    drive(1'b1, 1'b0, 3'b000, 4'hF, 4'hF, 4'hF, 32'hFBFB_FBFB, 32'h1);
    @(negedge clk);
    check("R6 clear", err_count, 32'd0);
    @(negedge clk);
    check("R6 clear held", err_count, 32'd0);
    check("R6 clear small", {24'b0, small_count}, 32'd0);
    exp_big = 0; exp_small = 0;

    // R9: saturation on the 8-bit copy
    for (int i = 0; i < 25; i++) begin
      drive(1'b1, 1'b0, 3'b000, 4'hF, 4'hF, 4'hF, 32'hFBFB_FBFB, 32'h0);
      add_exp(12);
      @(negedge clk);
      check("R9 sat count", {24'b0, small_count}, {24'b0, exp_small});
    end
    check("R9 saturated", {24'b0, small_count}, 32'd255);
    check("R2 wide keeps counting", err_count, 32'd300);

    drive(1'b0, 1'b0, 3'b000, 4'h0, 4'h0, 4'h0, 32'h0, 32'h0);
    @(negedge clk);
    check("R8 idle after sat", err_count, 32'd300);

    done = 1'b1;
    finish_run();
  end
endmodule